// File: doc/BRIEF.md
# Two-Bank Asynchronous SRAM Controller

This block sits between a simple host request port and a 32-bit array of asynchronous static RAM. The array is split into two banks. Each bank has one active-low select for its lower 16 data bits and one for its upper 16 data bits. A host request carries a word address, a bank bit, a size code, write data and a read/write flag. The controller turns it into registered select, write-strobe, output-enable, address and data-drive sequences. Every phase lasts a whole number of clock cycles. These counts are derived when the block is built: each nanosecond minimum of the memory is rounded up to whole clock periods.

A write holds the select low for one setup cycle before the write strobe falls. The select stays low while the strobe is low, and for at least one recovery cycle after it rises. The data bus is driven only while the strobe is low and the output enable is high.

A read holds the output enable low for the full access count and captures the bus on the last cycle of that count. The bits of a half that was not selected are forced to zero. Every read ends with idle turnaround cycles, so the memory releases the bus before the controller can drive it again. Completion of each request is signalled by a one-cycle ready pulse.

Top module: `sramc_top`

## Requirements
- R1: During reset and in the first cycle after reset, all four selects, the write strobe and the output enable are high, data drive is off, and ready is low. A reset during an access returns all of them to this state in the cycle after the reset edge.
- R2: Select index 2*b drives bits 0..15 of bank b and index 2*b+1 drives bits 16..31. Size code 2'b01 selects the low half only, 2'b10 selects the high half only, and 2'b00 or 2'b11 select both halves of the chosen bank. No other select is ever low.
- R3: With default timing, a write holds the write strobe low for exactly 3 consecutive cycles. A select of the access is low throughout that pulse.
- R4: The data bus is driven only while the write strobe is low and the output enable is high. While it is driven, it carries the write data captured from the request.
- R5: A write keeps its selects low for 5 cycles with default timing: 1 setup cycle, 3 pulse cycles and 1 recovery cycle. The address stays unchanged for as long as any select is low.
- R6: A read holds the output enable low and the write strobe high for exactly 4 cycles with default timing. It returns the bus value sampled in the last of those cycles, with the bits of the unselected half set to zero.
- R7: After a read, the selects, the write strobe and the output enable stay high, and data drive stays off, for at least the cycle after the ready pulse.
- R8: Ready is a single-cycle pulse. With default timing it comes 6 cycles after acceptance for a write (the cycle after recovery) and 5 cycles after acceptance for a read.
- R9: A request is accepted only while the controller is idle. A change to the request inputs after acceptance has no effect on the address, the selects or the stored data of the access in progress.
- R10: The memory address equals the accepted request address during the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | Bank number |
| req_size | input | 2 | 01 low half, 10 high half, 00/11 full word |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data, unselected half zeroed |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 4 | Active-low selects, two per bank |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DW | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | DW | Data read from the bus |

## Verification
The hardest case to reach from the ports is a host that changes its request fields while an access is already running. The bench corrupts bank, size, address and write data two cycles into every access. Later reads of the same words must still show only the originally requested values. The bench's memory model returns a poison value until the output enable has been low for the full access count, and it drives noise onto the unselected half. A capture that comes too early or a missing half mask therefore shows up in the returned data.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RACC,
    ST_TURN
  } seq_st_t;

  localparam logic [1:0] SZ_LO = 2'b01;
  localparam logic [1:0] SZ_HI = 2'b10;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_csdec.sv
module sramc_csdec #(
  parameter int NBANK  = 2,
  parameter int BANK_W = 1
) (
  input  logic [BANK_W-1:0]  bank,
  input  logic [1:0]         size,
  output logic [2*NBANK-1:0] sel_n,
  output logic [1:0]         half_en
);
  import sramc_pkg::*;

  // half_en[0]: bits of the low half, half_en[1]: bits of the high half
  assign half_en[0] = (size != SZ_HI);
  assign half_en[1] = (size != SZ_LO);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit            = (bank == BANK_W'(b));
    assign sel_n[2*b]     = !(hit && half_en[0]);
    assign sel_n[2*b + 1] = !(hit && half_en[1]);
  end

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq #(
  parameter int NCS    = 4,
  parameter int WP_C   = 3,
  parameter int HOLD_C = 1,
  parameter int ACC_C  = 4,
  parameter int TURN_C = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           is_write,
  input  logic [NCS-1:0] sel_n,
  output logic           idle,
  output logic           capture,
  output logic           done,
  output logic [NCS-1:0] cs_n,
  output logic           we_n,
  output logic           oe_n,
  output logic           dq_oe
);
  import sramc_pkg::*;

  localparam int MAXC  = imax(imax(WP_C, HOLD_C), imax(ACC_C, TURN_C));
  localparam int CNT_W = $clog2(MAXC + 1) + 1;

  seq_st_t            st, st_n;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic               done_n;
  logic               sel_on;

  assign idle = (st == ST_IDLE);

  always_comb begin
    st_n    = st;
    cnt_n   = cnt + 1'b1;
    done_n  = 1'b0;
    capture = 1'b0;
    unique case (st)
      ST_IDLE: begin
        cnt_n = '0;
        if (start) st_n = is_write ? ST_WSET : ST_RACC;
      end
      ST_WSET: begin
        cnt_n = '0;
        st_n  = ST_WPUL;
      end
      ST_WPUL: if (cnt == CNT_W'(WP_C - 1)) begin
        st_n  = ST_WHLD;
        cnt_n = '0;
      end
      ST_WHLD: if (cnt == CNT_W'(HOLD_C - 1)) begin
        st_n   = ST_IDLE;
        cnt_n  = '0;
        done_n = 1'b1;
      end
      ST_RACC: if (cnt == CNT_W'(ACC_C - 1)) begin
        st_n    = ST_TURN;
        cnt_n   = '0;
        done_n  = 1'b1;
        capture = 1'b1;
      end
      ST_TURN: if (cnt == CNT_W'(TURN_C - 1)) begin
        st_n  = ST_IDLE;
        cnt_n = '0;
      end
      default: begin
        st_n  = ST_IDLE;
        cnt_n = '0;
      end
    endcase
  end

  assign sel_on = (st_n == ST_WSET) || (st_n == ST_WPUL) ||
                  (st_n == ST_WHLD) || (st_n == ST_RACC);

  // strobes are registered from the next state so the pins never glitch
  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
      cs_n  <= '1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      done  <= done_n;
      cs_n  <= sel_on ? sel_n : '1;
      we_n  <= (st_n != ST_WPUL);
      oe_n  <= (st_n != ST_RACC);
      dq_oe <= (st_n == ST_WPUL);
    end
  end

endmodule

// File: rtl/sramc_top.sv
module sramc_top #(
  parameter int AW       = 19,
  parameter int DW       = 32,
  parameter int NBANK    = 2,
  parameter int CLK_NS   = 4,
  parameter int T_WP_NS  = 12,
  parameter int T_WC_NS  = 15,
  parameter int T_DS_NS  = 8,
  parameter int T_ACC_NS = 15,
  parameter int T_OE_NS  = 7,
  parameter int T_REL_NS = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_bank,
  input  logic [1:0]           req_size,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_ready,
  output logic [DW-1:0]        rsp_rdata,
  output logic [AW-1:0]        mem_addr,
  output logic [2*NBANK-1:0]   mem_cs_n,
  output logic                 mem_we_n,
  output logic                 mem_oe_n,
  output logic [DW-1:0]        mem_dq_out,
  output logic                 mem_dq_oe,
  input  logic [DW-1:0]        mem_dq_in
);
  import sramc_pkg::*;

  localparam int HALF   = DW / 2;
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int NCS    = 2 * NBANK;
  localparam int WP_C   = imax(1, imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS)));
  localparam int WC_C   = ns2cyc(T_WC_NS, CLK_NS);
  localparam int HOLD_C = imax(1, WC_C - 1 - WP_C);
  localparam int ACC_C  = imax(1, imax(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)));
  localparam int TURN_C = imax(1, ns2cyc(T_REL_NS, CLK_NS));

  logic              idle, accept, capture;
  logic [BANK_W-1:0] r_bank, d_bank;
  logic [1:0]        r_size, d_size;
  logic              r_write;
  logic [NCS-1:0]    sel_n;
  logic [1:0]        half_en;
  logic [DW-1:0]     rd_mask;

  assign accept = req_valid && idle;
  // while idle the decoder looks at the incoming request, later at the latch
  assign d_bank = accept ? BANK_W'(req_bank) : r_bank;
  assign d_size = accept ? req_size : r_size;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_bank     <= '0;
      r_size     <= '0;
      r_write    <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      r_bank     <= BANK_W'(req_bank);
      r_size     <= req_size;
      r_write    <= req_write;
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  sramc_csdec #(.NBANK(NBANK), .BANK_W(BANK_W)) u_dec (
    .bank    (d_bank),
    .size    (d_size),
    .sel_n   (sel_n),
    .half_en (half_en)
  );

  sramc_seq #(
    .NCS(NCS), .WP_C(WP_C), .HOLD_C(HOLD_C), .ACC_C(ACC_C), .TURN_C(TURN_C)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .is_write (accept ? req_write : r_write),
    .sel_n    (sel_n),
    .idle     (idle),
    .capture  (capture),
    .done     (rsp_ready),
    .cs_n     (mem_cs_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .dq_oe    (mem_dq_oe)
  );

  assign rd_mask = {{HALF{half_en[1]}}, {HALF{half_en[0]}}};

  always_ff @(posedge clk) begin
    if (rst)          rsp_rdata <= '0;
    else if (capture) rsp_rdata <= mem_dq_in & rd_mask;
  end

endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
  parameter int AW    = 19,
  parameter int NBANK = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [2*NBANK-1:0] mem_cs_n,
  input logic               mem_we_n,
  input logic               mem_oe_n,
  input logic               mem_dq_oe,
  input logic               rsp_ready,
  input logic [AW-1:0]      mem_addr
);
  localparam int NCS = 2 * NBANK;

  logic pair_ok;
  logic any_sel;

  assign any_sel = (mem_cs_n != '1);

  always_comb begin
    pair_ok = 1'b0;
    for (int b = 0; b < NBANK; b++)
      if (mem_cs_n == ~(NCS'(3) << (2 * b))) pair_ok = 1'b1;
  end

  a_r4_drive_in_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  a_r3_strobe_inside_select: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> any_sel);

  a_r6_read_strobes: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && any_sel));

  a_r2_at_most_two: assert property (@(posedge clk) disable iff (rst)
    $countones(~mem_cs_n) <= 2);

  a_r2_pair_in_bank: assert property (@(posedge clk) disable iff (rst)
    ($countones(~mem_cs_n) == 2) |-> pair_ok);

  a_r5_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (any_sel && $past(any_sel)) |-> $stable(mem_addr));

  a_r8_ready_single: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |=> !rsp_ready);

  a_r7_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |=> (!any_sel && mem_we_n && !mem_dq_oe));

endmodule

bind sramc_top sramc_chk #(.AW(AW), .NBANK(NBANK)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe),
  .rsp_ready (rsp_ready),
  .mem_addr  (mem_addr)
);

// File: tb/tb_sramc_top.sv
`timescale 1ns/1ps
module tb_sramc_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_bank = 1'b0;
  logic [1:0]  req_size = 2'b11;
  logic [18:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready;
  logic [31:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_we_n, mem_oe_n, mem_dq_oe;
  logic [31:0] mem_dq_out, mem_dq_in;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  sramc_top dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // ---------------- memory model: one 16-bit chip per select ----------------
  localparam int ACC_CYC = 4;   // 15 ns at 4 ns per cycle, rounded up
  logic [15:0] chip [4][256];
  logic [15:0] pend_d [4];
  logic [7:0]  pend_a [4];
  logic [3:0]  pend_v = '0;
  int          rd_cnt = 0;

  initial for (int c = 0; c < 4; c++) for (int a = 0; a < 256; a++) chip[c][a] = '0;

  always @(negedge clk) begin
    for (int c = 0; c < 4; c++) begin
      if (!mem_cs_n[c] && !mem_we_n) begin
        pend_v[c] = 1'b1;
        pend_a[c] = mem_addr[7:0];
        pend_d[c] = (c % 2 == 0) ? mem_dq_out[15:0] : mem_dq_out[31:16];
      end else if (pend_v[c]) begin
        chip[c][pend_a[c]] = pend_d[c];
        pend_v[c] = 1'b0;
      end
    end
    if (!mem_oe_n && mem_we_n && mem_cs_n != 4'hF) rd_cnt = rd_cnt + 1;
    else rd_cnt = 0;
  end

  always_comb begin
    mem_dq_in = 32'hBAD0BAD0;
    if (!mem_oe_n && mem_we_n && rd_cnt >= ACC_CYC) begin
      mem_dq_in = 32'hEEEEEEEE;
      if (!mem_cs_n[0]) mem_dq_in[15:0]  = chip[0][mem_addr[7:0]];
      if (!mem_cs_n[2]) mem_dq_in[15:0]  = chip[2][mem_addr[7:0]];
      if (!mem_cs_n[1]) mem_dq_in[31:16] = chip[1][mem_addr[7:0]];
      if (!mem_cs_n[3]) mem_dq_in[31:16] = chip[3][mem_addr[7:0]];
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input logic ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cs(input logic bank, input logic [1:0] size);
    logic [3:0] p;
    p = 4'hF;
    if (size != 2'b10) p[2*bank]     = 1'b0;
    if (size != 2'b01) p[2*bank + 1] = 1'b0;
    return p;
  endfunction

  task automatic run_req(input logic wr, input logic bank, input logic [1:0] size,
                         input logic [7:0] addr, input logic [31:0] wd,
                         input logic [31:0] exp);
    int n = 0, cs_cnt = 0, we_cnt = 0, oe_cnt = 0, dq_cnt = 0;
    int addr_bad = 0, dq_bad = 0;
    logic got = 1'b0, seen = 1'b0;
    logic [3:0] first_cs = 4'hF;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_bank = bank; req_size = size;
    req_addr = {11'b0, addr}; req_wdata = wd;
    while (!got && n < 50) begin
      @(negedge clk);
      n++;
      if (n == 2) begin  // R9: corrupt the request once it has been accepted
        req_bank = ~bank; req_size = ~size; req_addr = {11'h7FF, ~addr};
        req_wdata = ~wd;
      end
      if (mem_cs_n != 4'hF) begin
        cs_cnt++;
        if (!seen) begin first_cs = mem_cs_n; seen = 1'b1; end
        if (mem_addr != {11'b0, addr}) addr_bad++;
      end
      if (!mem_we_n) we_cnt++;
      if (!mem_oe_n) oe_cnt++;
      if (mem_dq_oe) begin
        dq_cnt++;
        if (mem_dq_out != wd || mem_we_n || !mem_oe_n) dq_bad++;
      end
      if (rsp_ready) got = 1'b1;
    end
    req_valid = 1'b0;
    check(first_cs == exp_cs(bank, size), "R2 select pattern", {28'b0, first_cs},
          {28'b0, exp_cs(bank, size)});
    check(addr_bad == 0, "R10 R9 address held", addr_bad, 0);
    if (wr) begin
      check(we_cnt == 3, "R3 write pulse cycles", we_cnt, 3);
      check(dq_cnt == 3 && dq_bad == 0, "R4 data drive window", dq_bad, 0);
      check(cs_cnt == 5, "R5 write select cycles", cs_cnt, 5);
      check(oe_cnt == 0, "R4 no output enable in write", oe_cnt, 0);
      check(n == 6, "R8 write ready latency", n, 6);
    end else begin
      check(oe_cnt == 4 && we_cnt == 0, "R6 read strobe cycles", oe_cnt, 4);
      check(cs_cnt == 4, "R6 read select cycles", cs_cnt, 4);
      check(rsp_rdata == exp, "R6 read data", rsp_rdata, exp);
      check(n == 5, "R8 read ready latency", n, 5);
    end
    @(negedge clk);
    check(!rsp_ready, "R8 ready single cycle", {31'b0, rsp_ready}, 0);
    if (!wr)
      check(mem_cs_n == 4'hF && mem_oe_n && mem_we_n && !mem_dq_oe,
            "R7 turnaround idle", {28'b0, mem_cs_n}, 32'hF);
  endtask

  // {write, bank, size, addr, wdata, expected read}
  localparam int NV = 12;
  localparam logic [75:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'b11, 8'h01, 32'h11223344, 32'h0},
    {1'b1, 1'b1, 2'b11, 8'h01, 32'h55667788, 32'h0},
    {1'b0, 1'b0, 2'b11, 8'h01, 32'h0,        32'h11223344},
    {1'b0, 1'b1, 2'b11, 8'h01, 32'h0,        32'h55667788},
    {1'b1, 1'b0, 2'b01, 8'h01, 32'hAAAABBBB, 32'h0},
    {1'b0, 1'b0, 2'b11, 8'h01, 32'h0,        32'h1122BBBB},
    {1'b1, 1'b1, 2'b10, 8'h01, 32'hCCCCDDDD, 32'h0},
    {1'b0, 1'b1, 2'b01, 8'h01, 32'h0,        32'h00007788},
    {1'b0, 1'b1, 2'b10, 8'h01, 32'h0,        32'hCCCC0000},
    {1'b1, 1'b0, 2'b00, 8'h02, 32'h0F0F0F0F, 32'h0},
    {1'b0, 1'b0, 2'b11, 8'h02, 32'h0,        32'h0F0F0F0F},
    {1'b0, 1'b1, 2'b11, 8'h02, 32'h0,        32'h00000000}
  };

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state right after reset
    check(mem_cs_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_ready,
          "R1 idle after reset", {28'b0, mem_cs_n}, 32'hF);
    check(rsp_rdata == 32'h0, "R1 read data cleared", rsp_rdata, 0);

    for (int i = 0; i < NV; i++)
      run_req(VEC[i][75], VEC[i][74], VEC[i][73:72], VEC[i][71:64],
              VEC[i][63:32], VEC[i][31:0]);

    // R1: reset in the middle of a write pulse
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_bank = 1'b1; req_size = 2'b11;
    req_addr = 19'h40; req_wdata = 32'h12345678;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    check(!mem_we_n, "R3 pulse active before reset", {31'b0, mem_we_n}, 0);
    rst = 1'b1;
    @(negedge clk);
    check(mem_cs_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_ready,
          "R1 idle after mid-access reset", {28'b0, mem_cs_n}, 32'hF);
    rst = 1'b0;

    // R6: data survives the abort sequence elsewhere
    run_req(1'b0, 1'b0, 2'b11, 8'h01, 32'h0, 32'h1122BBBB);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule